// File: doc/BRIEF.md
# Outbound Address Translation Window Table

This block sits between a host-side request source and a link-side transaction builder. It holds a small table of translation windows, each programmed through a simple register bus. A window has a source base, a power-of-two size, a translated base, a resource class and a transaction-layer packet type. Each host request carries a 64-bit address. The block compares that address against every enabled window at the same time. On a hit it returns the translated address, with the in-window offset kept, together with the window's resource class and packet type. A request that matches no window comes back flagged as a miss and sets a sticky error flag.

Requests enter on a valid/ready channel, and results leave on a valid/ready channel through a single output register. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in that same cycle. While `rsp_valid` is high and `rsp_ready` is low, the result is held unchanged and no new request is taken. The register bus carries no handshake. A write takes effect at the clock edge where its strobe is sampled. Read data is registered and appears on `reg_rdata` one cycle after the read strobe.

Top module: `atw_xlate`

## Requirements
- R1: After reset every window reads back as all zeros and is disabled, `rsp_valid` is low, and the miss flag is clear.
- R2: Window i occupies byte offsets 0x800 + 0x20*i. Its words are: +0x0 source low, +0x4 source high, +0x8 translated low, +0xC translated high, +0x10 parameters. In the source-low word, bit 0 is the enable, bits [6:1] hold a size field F, and bits [31:12] hold address bits [31:12]; bits [11:7] read as 0. The translated-low word keeps only bits [31:12]. The parameter word keeps the resource class in bits [3:0] and the packet type in bits [18:16]; all its other bits read as 0. Writes to +0x14..+0x1C are ignored, and those offsets read as 0. Read data appears one cycle after the read strobe.
- R3: A window spans 2^(F+1) bytes, naturally aligned. F = 63 covers the whole 64-bit space. A window with F+1 below 12 (smaller than 4 KiB) never matches.
- R4: A request hits a window when the address bits above the window size equal the corresponding source base bits. The result address is then the translated base's upper bits combined with the request's in-window offset bits.
- R5: On a hit, the resource class and packet type of the winning window are returned with the address.
- R6: When several windows match, the lowest-numbered one supplies the result.
- R7: A window whose enable bit is 0 never matches, whatever its other fields hold.
- R8: On a miss the result carries `rsp_hit`=0 and zero address, class and type. `miss_flag` sets and stays set until a register write of 1 to bit 0 at offset 0x900. Writing 0 there has no effect. A new miss in the same cycle as a clear leaves the flag set. Bit 0 at 0x900 reads the flag.
- R9: A request accepted at a clock edge is presented on the result port right after that edge, a fixed one-cycle latency. `req_ready` equals (not `rsp_valid`) or `rsp_ready`. A stalled result holds all its fields stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request can be taken |
| req_addr | input | 64 | Host-side request address |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_hit | output | 1 | Result came from a matching window |
| rsp_addr | output | 64 | Translated link-side address |
| rsp_res_id | output | 4 | Resource class of the winning window |
| rsp_tlp | output | 3 | Packet type of the winning window |
| miss_flag | output | 1 | Sticky unmatched-request flag |

## Verification
The bench probes both edges of a 1 MiB window: the last byte inside and the first byte past it. A mask that is off by one bit would either miss the last byte or translate the next one. It programs a 2 KiB window to catch a design that accepts windows below the minimum size. It programs a disabled window with otherwise valid fields to catch one that ignores the enable bit. Two overlapping windows are enabled and then the lower one is switched off, which shows whether selection really favours the lowest index. A whole-space window tests the F = 63 shift that could wrap to an empty mask. A stall with a second request waiting exposes a result register that changes while held, and a ready signal that lets the waiting request overwrite the held result.

// File: rtl/atw_pkg.sv
`timescale 1ns/1ps
package atw_pkg;
  localparam int ADDR_W  = 64;
  localparam int MIN_EXP = 12;
  localparam int PG_W    = 32 - MIN_EXP;
  localparam int RES_W   = 4;
  localparam int TLP_W   = 3;
  localparam int TLP_LSB = 16;

  typedef enum logic [2:0] {
    WD_SRC_LO = 3'd0,
    WD_SRC_HI = 3'd1,
    WD_DST_LO = 3'd2,
    WD_DST_HI = 3'd3,
    WD_PARAM  = 3'd4
  } word_e;

  typedef struct packed {
    logic              hit;
    logic [ADDR_W-1:0] addr;
    logic [RES_W-1:0]  res_id;
    logic [TLP_W-1:0]  tlp;
  } xlat_t;
endpackage

// File: rtl/atw_window.sv
`timescale 1ns/1ps
// One translation window: its programmable fields and its address comparator.
module atw_window
  import atw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  word_e             word_sel,
  input  logic [31:0]       wdata,
  output logic [31:0]       rd_word,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              hit,
  output logic [ADDR_W-1:0] xlat_addr,
  output logic [RES_W-1:0]  res_id,
  output logic [TLP_W-1:0]  tlp
);
  logic             en_q;
  logic [5:0]       szf_q;
  logic [PG_W-1:0]  src_lo_q;
  logic [31:0]      src_hi_q;
  logic [PG_W-1:0]  dst_lo_q;
  logic [31:0]      dst_hi_q;
  logic [RES_W-1:0] res_q;
  logic [TLP_W-1:0] tlp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      szf_q    <= '0;
      src_lo_q <= '0;
      src_hi_q <= '0;
      dst_lo_q <= '0;
      dst_hi_q <= '0;
      res_q    <= '0;
      tlp_q    <= '0;
    end else if (wr_en) begin
      case (word_sel)
        WD_SRC_LO: begin
          en_q     <= wdata[0];
          szf_q    <= wdata[6:1];
          src_lo_q <= wdata[31:MIN_EXP];
        end
        WD_SRC_HI: src_hi_q <= wdata;
        WD_DST_LO: dst_lo_q <= wdata[31:MIN_EXP];
        WD_DST_HI: dst_hi_q <= wdata;
        WD_PARAM: begin
          res_q <= wdata[RES_W-1:0];
          tlp_q <= wdata[TLP_LSB +: TLP_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_word = '0;
    case (word_sel)
      WD_SRC_LO: rd_word = {src_lo_q, 5'b0, szf_q, en_q};
      WD_SRC_HI: rd_word = src_hi_q;
      WD_DST_LO: rd_word = {dst_lo_q, {MIN_EXP{1'b0}}};
      WD_DST_HI: rd_word = dst_hi_q;
      WD_PARAM: begin
        rd_word[RES_W-1:0]          = res_q;
        rd_word[TLP_LSB +: TLP_W]   = tlp_q;
      end
      default: rd_word = '0;
    endcase
  end

  // Window exponent is the size field plus one; a shift of 64 clears fully.
  logic [6:0]        win_exp;
  logic [ADDR_W-1:0] off_mask;
  logic [ADDR_W-1:0] src_base;
  logic [ADDR_W-1:0] dst_base;
  logic              size_ok;

  always_comb begin
    win_exp  = {1'b0, szf_q} + 7'd1;
    off_mask = ~({ADDR_W{1'b1}} << win_exp);
    size_ok  = (win_exp >= 7'(MIN_EXP));
    src_base = {src_hi_q, src_lo_q, {MIN_EXP{1'b0}}};
    dst_base = {dst_hi_q, dst_lo_q, {MIN_EXP{1'b0}}};
    hit       = en_q && size_ok && (((req_addr ^ src_base) & ~off_mask) == '0);
    xlat_addr = (dst_base & ~off_mask) | (req_addr & off_mask);
    res_id    = res_q;
    tlp       = tlp_q;
  end
endmodule

// File: rtl/atw_pick.sv
`timescale 1ns/1ps
// Fixed-priority selector: the lowest-numbered asserted input wins.
module atw_pick #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic [IDX_W-1:0] sel,
  output logic [N-1:0]     grant
);
  always_comb begin
    any   = 1'b0;
    sel   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        sel = IDX_W'(i);
        any = 1'b1;
      end
    end
    if (any) grant[sel] = 1'b1;
  end

  // R6: at most one window is granted per request
  a_r6_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: rtl/atw_xlate.sv
`timescale 1ns/1ps
module atw_xlate
  import atw_pkg::*;
#(
  parameter int          N_WIN     = 8,
  parameter logic [11:0] TBL_BASE  = 12'h800,
  parameter logic [11:0] STAT_ADDR = 12'h900
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [63:0]       rsp_addr,
  output logic [3:0]        rsp_res_id,
  output logic [2:0]        rsp_tlp,
  output logic              miss_flag
);
  localparam int          IDX_W    = (N_WIN > 1) ? $clog2(N_WIN) : 1;
  localparam int          STRIDE_SH = 5;
  localparam logic [12:0] TBL_SPAN = 13'(N_WIN << STRIDE_SH);

  // ---------------- register decode ----------------
  logic [11:0]      rel;
  logic             in_tbl;
  logic             word_ok;
  logic [IDX_W-1:0] win_idx;
  word_e            word_sel;
  logic             stat_clr;

  always_comb begin
    rel      = reg_addr - TBL_BASE;
    in_tbl   = (reg_addr >= TBL_BASE) && ({1'b0, rel} < TBL_SPAN);
    word_ok  = (rel[4:2] <= 3'd4) && (rel[1:0] == 2'b00);
    win_idx  = rel[STRIDE_SH +: IDX_W];
    word_sel = word_e'(rel[4:2]);
    stat_clr = reg_wr && (reg_addr == STAT_ADDR) && reg_wdata[0];
  end

  // ---------------- window array ----------------
  logic [N_WIN-1:0] hit_vec;
  logic [31:0]      win_rd   [N_WIN];
  logic [63:0]      win_addr [N_WIN];
  logic [3:0]       win_res  [N_WIN];
  logic [2:0]       win_tlp  [N_WIN];

  for (genvar gi = 0; gi < N_WIN; gi++) begin : g_win
    logic wr_sel;
    assign wr_sel = reg_wr && in_tbl && word_ok && (win_idx == IDX_W'(gi));
    atw_window u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_sel),
      .word_sel  (word_sel),
      .wdata     (reg_wdata),
      .rd_word   (win_rd[gi]),
      .req_addr  (req_addr),
      .hit       (hit_vec[gi]),
      .xlat_addr (win_addr[gi]),
      .res_id    (win_res[gi]),
      .tlp       (win_tlp[gi])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] sel_idx;
  logic [N_WIN-1:0] grant;

  atw_pick #(.N(N_WIN), .IDX_W(IDX_W)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .hits  (hit_vec),
    .any   (any_hit),
    .sel   (sel_idx),
    .grant (grant)
  );

  // ---------------- register read ----------------
  logic [31:0] rdata_q;
  logic        miss_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      if (reg_addr == STAT_ADDR)      rdata_q <= {31'b0, miss_q};
      else if (in_tbl && word_ok)     rdata_q <= win_rd[win_idx];
      else                            rdata_q <= '0;
    end
  end
  assign reg_rdata = rdata_q;

  // ---------------- result stage ----------------
  xlat_t nxt;
  xlat_t rsp_q;
  logic  rsp_v_q;
  logic  accept;

  always_comb begin
    nxt = '0;
    if (any_hit) begin
      nxt.hit    = 1'b1;
      nxt.addr   = win_addr[sel_idx];
      nxt.res_id = win_res[sel_idx];
      nxt.tlp    = win_tlp[sel_idx];
    end
  end

  assign req_ready = !rsp_v_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_q   <= '0;
    end else if (accept) begin
      rsp_v_q <= 1'b1;
      rsp_q   <= nxt;
    end else if (rsp_ready) begin
      rsp_v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  miss_q <= 1'b0;
    else if (accept && !any_hit) miss_q <= 1'b1;
    else if (stat_clr)           miss_q <= 1'b0;
  end

  assign rsp_valid  = rsp_v_q;
  assign rsp_hit    = rsp_q.hit;
  assign rsp_addr   = rsp_q.addr;
  assign rsp_res_id = rsp_q.res_id;
  assign rsp_tlp    = rsp_q.tlp;
  assign miss_flag  = miss_q;

  // ---------------- assertions ----------------
  // R9: an accepted request yields a result on the next cycle
  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R9: a stalled result stays put
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) &&
                                   $stable(rsp_hit) && $stable(rsp_tlp)));

  // R8: an unmatched request raises the flag
  a_r8_miss_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !any_hit) |=> miss_flag);

  // R8: the flag only drops on an explicit clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_flag && !stat_clr) |=> miss_flag);

  // R8: a miss result carries no address
  a_r8_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == '0));

  // R6: the selected window is one that actually matched
  a_r6_sel_hit: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> hit_vec[sel_idx]);
endmodule

// File: tb/atw_xlate_test.sv
`timescale 1ns/1ps
module atw_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic [63:0] rsp_addr;
  logic [3:0]  rsp_res_id;
  logic [2:0]  rsp_tlp;
  logic        miss_flag;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  atw_xlate uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_addr(rsp_addr), .rsp_res_id(rsp_res_id), .rsp_tlp(rsp_tlp),
    .miss_flag(miss_flag)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic send(input logic [63:0] a, output logic h, output logic [63:0] x,
                      output logic [3:0] r, output logic [2:0] t);
    @(negedge clk);
    rsp_ready = 1'b1; req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    h = rsp_hit; x = rsp_addr; r = rsp_res_id; t = rsp_tlp;
    chk("R9 result valid after one cycle", {63'b0, rsp_valid}, 64'd1);
  endtask

  task automatic win(input int i, input logic [31:0] slo, input logic [31:0] shi,
                     input logic [31:0] dlo, input logic [31:0] dhi, input logic [31:0] prm);
    logic [11:0] b;
    b = 12'h800 + 12'(i * 32);
    reg_write(b + 12'h00, slo);
    reg_write(b + 12'h04, shi);
    reg_write(b + 12'h08, dlo);
    reg_write(b + 12'h0C, dhi);
    reg_write(b + 12'h10, prm);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 rsp_valid after reset", {63'b0, rsp_valid}, 64'd0);
    chk("R1 miss_flag after reset", {63'b0, miss_flag}, 64'd0);
    reg_read(12'h800, d); chk("R1 window0 word0 zero", {32'b0, d}, 64'd0);
    reg_read(12'h8F0, d); chk("R1 window7 param zero", {32'b0, d}, 64'd0);
    reg_read(12'h900, d); chk("R1 status zero", {32'b0, d}, 64'd0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    win(3, 32'hABCDE7FF, 32'h11223344, 32'h12345FFF, 32'h55667788, 32'hFFFFFFFF);
    reg_write(12'h874, 32'hDEADBEEF);
    reg_read(12'h860, d); chk("R2 source low masks bits 11:7", {32'b0, d}, 64'hABCDE07F);
    reg_read(12'h864, d); chk("R2 source high", {32'b0, d}, 64'h11223344);
    reg_read(12'h868, d); chk("R2 translated low keeps 31:12", {32'b0, d}, 64'h12345000);
    reg_read(12'h86C, d); chk("R2 translated high", {32'b0, d}, 64'h55667788);
    reg_read(12'h870, d); chk("R2 param keeps class and type", {32'b0, d}, 64'h0007000F);
    reg_read(12'h874, d); chk("R2 spare offset reads zero", {32'b0, d}, 64'd0);
    reg_write(12'h860, 32'h0);
  endtask

  task automatic t_basic_hit;
    logic h; logic [63:0] x; logic [3:0] r; logic [2:0] t;
    win(0, 32'h20000027, 32'h0, 32'h80000000, 32'h1, 32'h0);
    send(64'h0000_0000_2001_2345, h, x, r, t);
    chk("R4 hit flag", {63'b0, h}, 64'd1);
    chk("R4 translated address", x, 64'h0000_0001_8001_2345);
    send(64'h0000_0000_200F_FFFF, h, x, r, t);
    chk("R3 last byte of 1 MiB window", x, 64'h0000_0001_800F_FFFF);
    send(64'h0000_0000_2010_0000, h, x, r, t);
    chk("R3 first byte past window misses", {63'b0, h}, 64'd0);
  endtask

  task automatic t_miss_sticky;
    logic h; logic [63:0] x; logic [3:0] r; logic [2:0] t; logic [31:0] d;
    chk("R8 flag set by earlier miss", {63'b0, miss_flag}, 64'd1);
    send(64'h0000_0000_7000_0000, h, x, r, t);
    chk("R8 miss address zero", x, 64'd0);
    chk("R8 miss class/type zero", {57'b0, r, t}, 64'd0);
    send(64'h0000_0000_2000_0010, h, x, r, t);
    chk("R8 flag stays set across a hit", {63'b0, miss_flag}, 64'd1);
    reg_read(12'h900, d); chk("R8 status reads flag", {32'b0, d}, 64'd1);
    reg_write(12'h900, 32'h0);
    chk("R8 writing zero keeps flag", {63'b0, miss_flag}, 64'd1);
    reg_write(12'h900, 32'h1);
    chk("R8 writing one clears flag", {63'b0, miss_flag}, 64'd0);
  endtask

  task automatic t_io_window;
    logic h; logic [63:0] x; logic [3:0] r; logic [2:0] t;
    win(1, 32'h30000017, 32'h2, 32'h0, 32'h0, 32'h00020001);
    send(64'h0000_0002_3000_0ABC, h, x, r, t);
    chk("R4 upper-word source match", x, 64'h0000_0000_0000_0ABC);
    chk("R5 resource class I/O", {60'b0, r}, 64'd1);
    chk("R5 packet type I/O", {61'b0, t}, 64'd2);
    send(64'h0000_0000_3000_0ABC, h, x, r, t);
    chk("R4 differing high word misses", {63'b0, h}, 64'd0);
    reg_write(12'h900, 32'h1);
  endtask

  task automatic t_min_and_enable;
    logic h; logic [63:0] x; logic [3:0] r; logic [2:0] t;
    win(2, 32'h40000015, 32'h0, 32'h50000000, 32'h0, 32'h0);
    send(64'h0000_0000_4000_0010, h, x, r, t);
    chk("R3 2 KiB window never matches", {63'b0, h}, 64'd0);
    reg_write(12'h840, 32'h40000016);
    send(64'h0000_0000_4000_0010, h, x, r, t);
    chk("R7 disabled window never matches", {63'b0, h}, 64'd0);
    reg_write(12'h840, 32'h40000017);
    send(64'h0000_0000_4000_0010, h, x, r, t);
    chk("R7 enabled 4 KiB window matches", x, 64'h0000_0000_5000_0010);
    reg_write(12'h900, 32'h1);
  endtask

  task automatic t_priority;
    logic h; logic [63:0] x; logic [3:0] r; logic [2:0] t;
    win(4, 32'h20000027, 32'h0, 32'h90000000, 32'h0, 32'h0);
    send(64'h0000_0000_2000_0040, h, x, r, t);
    chk("R6 lower window wins overlap", x, 64'h0000_0001_8000_0040);
    reg_write(12'h800, 32'h20000026);
    send(64'h0000_0000_2000_0040, h, x, r, t);
    chk("R6 next window after disable", x, 64'h0000_0000_9000_0040);
  endtask

  task automatic t_full_space;
    logic h; logic [63:0] x; logic [3:0] r; logic [2:0] t;
    win(5, 32'h0000007F, 32'h0, 32'h0, 32'h0, 32'h0);
    send(64'hFFFF_FFFF_FFFF_FFF0, h, x, r, t);
    chk("R3 whole-space window hit", {63'b0, h}, 64'd1);
    chk("R3 whole-space offset passes through", x, 64'hFFFF_FFFF_FFFF_FFF0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 64'h0000_0000_2000_0100;
    @(negedge clk);
    req_addr = 64'h0000_0000_7777_0000;
    chk("R9 stalled result valid", {63'b0, rsp_valid}, 64'd1);
    chk("R9 ready low while stalled", {63'b0, req_ready}, 64'd0);
    chk("R9 first result", rsp_addr, 64'h0000_0000_9000_0100);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R9 result held during stall", rsp_addr, 64'h0000_0000_9000_0100);
      chk("R9 ready stays low", {63'b0, req_ready}, 64'd0);
    end
    rsp_ready = 1'b1;
    #0.1;
    chk("R9 ready follows consumer", {63'b0, req_ready}, 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 queued request follows", rsp_addr, 64'h0000_0000_7777_0000);
    chk("R9 queued result valid", {63'b0, rsp_valid}, 64'd1);
    @(negedge clk);
    chk("R9 drained", {63'b0, rsp_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_basic_hit();
    t_miss_sticky();
    t_io_window();
    t_min_and_enable();
    t_priority();
    t_full_space();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule